// File: doc/BRIEF.md
# Master-Mode Serial Audio Receiver with Channel Filter and Word Packer

The block drives the bit clock and the word-select line of a three-wire serial audio link as its master. It shifts in the serial data line and keeps the left slot, the right slot, or both. It packs the kept samples into 32-bit words in a 128-entry receive FIFO, and a consumer drains the FIFO through a show-ahead read port. A programmable count of accepted words raises a one-cycle end-of-frame pulse, which a downstream mover can use as its transfer request.

Each frame holds 64 bit clocks. Word select is low for the 32-bit left slot and high for the 32-bit right slot. A sample starts on the second bit clock of its slot, most significant bit first, and the receiver samples the data line on the rising bit-clock edge. The configuration inputs are expected to stay steady while the receiver runs. The receive logic and the FIFO each have their own synchronous soft reset, held high and then released.

Top module: `i2s_rx_master`

## Requirements
- R1: After reset, bck_o and ws_o are low, rd_valid is low and ovf_o is low. While cfg_start is low, bck_o keeps its level.
- R2: While cfg_start is high, bck_o toggles every (cfg_pre_div+1)*(cfg_bit_div+1) clk cycles. ws_o changes only when bck_o falls, and is low for the left slot and high for the right slot of 32 bit clocks each. Sample bits are taken MSB first on rising bck_o, at slot bit positions 1 to 16 (16-bit modes) or 1 to 24 (24-bit modes).
- R3: Pack code 0 (16-bit stereo) joins two kept 16-bit samples into one word, with the earlier sample in bits 31:16 and the later one in bits 15:0.
- R4: Pack code 1 (16-bit mono) writes one word per kept sample, with the sample in bits 31:16 and bits 15:0 zero.
- R5: Pack codes 2 and 3 (24-bit stereo and mono) write one word per kept sample, with the sample in bits 23:0 and bits 31:24 zero.
- R6: In the stereo pack codes 0 and 2, channel code 0 keeps both slots in left-then-right order, code 1 keeps only the right slot, code 2 keeps only the left slot, and code 3 keeps none.
- R7: In the mono pack codes 1 and 3, channel code 1 keeps only the right slot, codes 0 and 2 keep only the left slot, and code 3 keeps none.
- R8: Pack codes 4 to 7 write nothing to the FIFO.
- R9: eof_o pulses high for one cycle each time cfg_eof_words words have been accepted since the last pulse or receive reset. A value of 0 disables the pulse.
- R10: The FIFO returns words in the order they were written and holds up to 128 of them. rd_valid is high while it holds any word, rd_data shows the oldest word, and rd_en with rd_valid high removes that word.
- R11: A word that arrives while the FIFO is full is dropped and sets ovf_o, which stays set until cfg_fifo_rst. cfg_fifo_rst empties the FIFO and clears ovf_o.
- R12: cfg_rx_rst returns bck_o and ws_o low, discards a half-built 16-bit pair and clears the end-of-frame count. It leaves the FIFO contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Run the bit clock and capture |
| cfg_rx_rst | input | 1 | Synchronous soft reset of the receive logic |
| cfg_fifo_rst | input | 1 | Synchronous soft reset of the FIFO and the overflow flag |
| cfg_pack | input | 3 | Packing code (0 to 3 legal) |
| cfg_chan | input | 2 | Channel keep code |
| cfg_pre_div | input | DIVW | Prescaler value, divides by value+1 |
| cfg_bit_div | input | DIVW | Bit-clock divider value, divides by value+1 |
| cfg_eof_words | input | EOFW | Accepted words per end-of-frame pulse |
| sd_i | input | 1 | Serial data in |
| bck_o | output | 1 | Bit clock out |
| ws_o | output | 1 | Word select out, 0 = left |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| rd_valid | output | 1 | FIFO is not empty |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Overflow is the hardest state to reach from the ports, because it needs more than 128 accepted words with no reads in between. The bench runs 66 dual-channel 24-bit frames at the fastest bit clock and holds rd_en low, so 132 samples arrive. It then drains the FIFO and expects exactly the first 128 words, with ovf_o still set until the FIFO reset. A second hard case is a 16-bit pair left half-built when the receive reset arrives. The bench keeps only the left slot for an odd number of frames, resets, and checks that the next pair starts fresh while the words already in the FIFO are still there.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    // packing codes
    typedef enum logic [2:0] {
        PK_S16 = 3'd0,
        PK_M16 = 3'd1,
        PK_S24 = 3'd2,
        PK_M24 = 3'd3
    } pack_e;

    // channel keep codes
    typedef enum logic [1:0] {
        CH_BOTH  = 2'd0,
        CH_RIGHT = 2'd1,
        CH_LEFT  = 2'd2,
        CH_NONE  = 2'd3
    } chan_e;

    // one captured sample, right-aligned
    typedef struct packed {
        logic        valid;
        logic        right;
        logic [23:0] data;
    } smp_t;
endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
    parameter int DIVW = 6,
    parameter int BITW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [DIVW-1:0] pre_div,
    input  logic [DIVW-1:0] bit_div,
    output logic            bck,
    output logic            ws,
    output logic            rise,
    output logic [BITW-1:0] bitpos
);
    localparam int HW = 2 * DIVW + 1;

    typedef struct packed {
        logic [HW-1:0]   cnt;
        logic            bck;
        logic [BITW-1:0] pos;
    } st_t;

    st_t           s_q, s_d;
    logic [HW-1:0] half;
    logic          tick;

    always_comb begin
        half = (HW'(pre_div) + HW'(1)) * (HW'(bit_div) + HW'(1));
        tick = run && (s_q.cnt >= half - HW'(1));
        s_d  = s_q;
        if (clr) begin
            s_d = '0;
        end else if (run) begin
            if (tick) begin
                s_d.cnt = '0;
                s_d.bck = ~s_q.bck;
                if (s_q.bck) s_d.pos = s_q.pos + 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    assign rise   = tick && !clr && !s_q.bck;
    assign bck    = s_q.bck;
    assign ws     = s_q.pos[BITW-1];
    assign bitpos = s_q.pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: a stopped unit holds the bit clock
    p_bck_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(bck));

    // R2: word select moves only on a falling bit clock
    p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ws) && $past(!clr)) |-> $fell(bck));
endmodule

// File: rtl/i2s_rx_shift.sv
module i2s_rx_shift
    import i2s_rx_pkg::*;
#(
    parameter int BITW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            rise,
    input  logic            sd,
    input  logic            wide,
    input  logic [BITW-1:0] bitpos,
    output smp_t            smp
);
    localparam int OFFW = BITW - 1;

    typedef struct packed {
        logic [22:0] sh;
        smp_t        smp;
    } st_t;

    st_t            s_q, s_d;
    logic [OFFW-1:0] off;
    logic [OFFW-1:0] last;

    always_comb begin
        off  = bitpos[OFFW-1:0];
        last = wide ? OFFW'(24) : OFFW'(16);
        s_d  = s_q;
        s_d.smp.valid = 1'b0;
        if (clr) begin
            s_d = '0;
        end else if (rise && off != '0 && off <= last) begin
            s_d.sh = {s_q.sh[21:0], sd};
            if (off == last) begin
                s_d.smp.valid = 1'b1;
                s_d.smp.right = bitpos[BITW-1];
                s_d.smp.data  = wide ? {s_q.sh, sd} : {8'h00, s_q.sh[14:0], sd};
            end
        end
    end

    assign smp = s_q.smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: a sample completes only right after a rising bit clock
    p_smp_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp.valid |-> $past(rise));
endmodule

// File: rtl/i2s_rx_pack.sv
module i2s_rx_pack
    import i2s_rx_pkg::*;
#(
    parameter int EOFW  = 8,
    parameter int WORDW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  smp_t             smp,
    input  logic [2:0]       pack_mode,
    input  logic [1:0]       chan_mode,
    input  logic [EOFW-1:0]  eof_words,
    input  logic             full,
    output logic             wr,
    output logic [WORDW-1:0] wr_data,
    output logic             eof
);
    typedef struct packed {
        logic             have;
        logic [15:0]      half;
        logic             wr;
        logic [WORDW-1:0] data;
        logic [EOFW-1:0]  cnt;
        logic             eof;
    } st_t;

    st_t  s_q, s_d;
    logic mono, keep, legal;

    always_comb begin
        mono  = (pack_mode == PK_M16) || (pack_mode == PK_M24);
        legal = (pack_mode <= PK_M24);
        case (chan_mode)
            CH_BOTH:  keep = mono ? !smp.right : 1'b1;
            CH_RIGHT: keep = smp.right;
            CH_LEFT:  keep = !smp.right;
            default:  keep = 1'b0;
        endcase

        s_d     = s_q;
        s_d.wr  = 1'b0;
        s_d.eof = 1'b0;

        // count words the FIFO actually took
        if (s_q.wr && !full) begin
            if (eof_words != '0 && (s_q.cnt + 1'b1) >= eof_words) begin
                s_d.cnt = '0;
                s_d.eof = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (smp.valid && keep && legal) begin
            case (pack_mode)
                PK_S16: begin
                    if (s_q.have) begin
                        s_d.wr   = 1'b1;
                        s_d.data = {s_q.half, smp.data[15:0]};
                        s_d.have = 1'b0;
                    end else begin
                        s_d.half = smp.data[15:0];
                        s_d.have = 1'b1;
                    end
                end
                PK_M16: begin
                    s_d.wr   = 1'b1;
                    s_d.data = {smp.data[15:0], 16'h0000};
                end
                default: begin
                    s_d.wr   = 1'b1;
                    s_d.data = {8'h00, smp.data};
                end
            endcase
        end

        if (clr) s_d = '0;
    end

    assign wr      = s_q.wr;
    assign wr_data = s_q.data;
    assign eof     = s_q.eof;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: end-of-frame is a single-cycle pulse
    p_eof_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    // R8: illegal pack codes never produce a word
    p_wr_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(pack_mode <= 3'd3));
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             not_empty,
    output logic             full,
    output logic             ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } st_t;

    st_t              s_q, s_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             push, pop;

    always_comb begin
        full      = (s_q.cnt == CW'(DEPTH));
        not_empty = (s_q.cnt != '0);
        push      = wr && !full && !clr;
        pop       = rd && not_empty && !clr;
        s_d       = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
            if (pop)  s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
            if (push && !pop) s_d.cnt = s_q.cnt + 1'b1;
            if (pop && !push) s_d.cnt = s_q.cnt - 1'b1;
            if (wr && full)   s_d.ovf = 1'b1;
        end
    end

    assign rd_data = mem[s_q.rp];
    assign ovf     = s_q.ovf;

    always_ff @(posedge clk) begin
        if (push) mem[s_q.wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10: occupancy never exceeds the depth
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R11: overflow flag is sticky until the FIFO reset
    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R11: a full FIFO with no read stays full
    p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd && !clr) |=> full);
endmodule

// File: rtl/i2s_rx_master.sv
module i2s_rx_master
    import i2s_rx_pkg::*;
#(
    parameter int DIVW  = 6,
    parameter int EOFW  = 8,
    parameter int DEPTH = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_start,
    input  logic            cfg_rx_rst,
    input  logic            cfg_fifo_rst,
    input  logic [2:0]      cfg_pack,
    input  logic [1:0]      cfg_chan,
    input  logic [DIVW-1:0] cfg_pre_div,
    input  logic [DIVW-1:0] cfg_bit_div,
    input  logic [EOFW-1:0] cfg_eof_words,
    input  logic            sd_i,
    output logic            bck_o,
    output logic            ws_o,
    input  logic            rd_en,
    output logic [31:0]     rd_data,
    output logic            rd_valid,
    output logic            eof_o,
    output logic            ovf_o
);
    localparam int SLOT_BITS = 32;
    localparam int BITW      = $clog2(2 * SLOT_BITS);
    localparam int WORDW     = 32;

    logic             rise;
    logic [BITW-1:0]  bitpos;
    smp_t             smp;
    logic             wr, full;
    logic [WORDW-1:0] wr_data;
    logic             wide;

    assign wide = cfg_pack[2] | cfg_pack[1];

    i2s_rx_clkgen #(.DIVW(DIVW), .BITW(BITW)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_rx_rst), .run(cfg_start),
        .pre_div(cfg_pre_div), .bit_div(cfg_bit_div),
        .bck(bck_o), .ws(ws_o), .rise(rise), .bitpos(bitpos)
    );

    i2s_rx_shift #(.BITW(BITW)) shift_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_rx_rst), .rise(rise), .sd(sd_i),
        .wide(wide), .bitpos(bitpos), .smp(smp)
    );

    i2s_rx_pack #(.EOFW(EOFW), .WORDW(WORDW)) pack_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_rx_rst), .smp(smp),
        .pack_mode(cfg_pack), .chan_mode(cfg_chan), .eof_words(cfg_eof_words),
        .full(full), .wr(wr), .wr_data(wr_data), .eof(eof_o)
    );

    i2s_rx_fifo #(.DEPTH(DEPTH), .WIDTH(WORDW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_fifo_rst), .wr(wr), .wr_data(wr_data),
        .rd(rd_en), .rd_data(rd_data), .not_empty(rd_valid), .full(full), .ovf(ovf_o)
    );
endmodule

// File: tb/i2s_rx_master_tb.sv
module i2s_rx_master_tb_top;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 128;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_start, cfg_rx_rst, cfg_fifo_rst;
    logic [2:0]  cfg_pack;
    logic [1:0]  cfg_chan;
    logic [5:0]  cfg_pre_div, cfg_bit_div;
    logic [7:0]  cfg_eof_words;
    logic        sd_i;
    logic        bck_o, ws_o, rd_en, rd_valid, eof_o, ovf_o;
    logic [31:0] rd_data;

    i2s_rx_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_rx_rst(cfg_rx_rst),
        .cfg_fifo_rst(cfg_fifo_rst), .cfg_pack(cfg_pack), .cfg_chan(cfg_chan),
        .cfg_pre_div(cfg_pre_div), .cfg_bit_div(cfg_bit_div),
        .cfg_eof_words(cfg_eof_words), .sd_i(sd_i), .bck_o(bck_o), .ws_o(ws_o),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .eof_o(eof_o),
        .ovf_o(ovf_o)
    );

    always #(PERIOD / 2) clk = ~clk;

    int          nchk = 0;
    int          nerr = 0;
    logic [31:0] exp_q [$];
    logic [31:0] seed = 32'h1234_5678;
    int          m_pm = 0, m_cm = 0, m_w = 16;
    int          off = 0;
    logic        prev_ws = 1'b0;
    logic [23:0] cur = '0;
    logic        have = 1'b0;
    logic [15:0] hv = '0;
    int          accepted = 0;
    int          eof_seen = 0;
    logic        ovf_exp = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [23:0] gen();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:7];
    endfunction

    task automatic emit(input logic [31:0] w);
        if (exp_q.size() >= DEPTH) ovf_exp = 1'b1;
        else begin
            exp_q.push_back(w);
            accepted++;
        end
    endtask

    // reference of keep and packing rules (R3..R8)
    task automatic model_push(input logic right, input logic [23:0] v);
        bit mono, keep;
        mono = (m_pm == 1) || (m_pm == 3);
        case (m_cm)
            0:       keep = mono ? !right : 1'b1;
            1:       keep = right;
            2:       keep = !right;
            default: keep = 1'b0;
        endcase
        if (!keep || m_pm > 3) return;
        if (m_pm == 0) begin
            if (have) begin
                emit({hv, v[15:0]});
                have = 1'b0;
            end else begin
                hv   = v[15:0];
                have = 1'b1;
            end
        end else if (m_pm == 1) emit({v[15:0], 16'h0000});
        else emit({8'h00, v});
    endtask

    // serial transmitter: new bit after each falling bit clock
    always @(negedge bck_o) begin
        #1;
        if (ws_o !== prev_ws) begin
            prev_ws = ws_o;
            off     = 0;
            cur     = gen();
        end else off++;
        sd_i = (off >= 1 && off <= m_w) ? cur[m_w - off] : 1'b0;
    end

    always @(posedge bck_o) begin
        if (off == m_w) model_push(prev_ws, cur);
    end

    always @(negedge clk) begin
        if (rst_n && eof_o) eof_seen++;
    end

    task automatic drain(input string tag);
        forever begin
            @(negedge clk);
            rd_en = 1'b0;
            chk(rd_valid == (exp_q.size() != 0), {tag, " rd_valid"},
                32'(rd_valid), 32'(exp_q.size() != 0));
            if (!rd_valid || exp_q.size() == 0) break;
            chk(rd_data == exp_q[0], tag, rd_data, exp_q[0]);
            void'(exp_q.pop_front());
            rd_en = 1'b1;
        end
        rd_en = 1'b0;
        exp_q.delete();
    endtask

    task automatic run_test(input int pm, input int cm, input int pdiv, input int bdiv,
                            input int eofw, input int frames, input bit measure,
                            input bit rst_before_drain, input bit do_drain,
                            input string tag);
        time t0;
        int  expect_eof;
        @(negedge clk);
        cfg_start     = 1'b0;
        cfg_rx_rst    = 1'b1;
        cfg_pack      = 3'(pm);
        cfg_chan      = 2'(cm);
        cfg_pre_div   = 6'(pdiv);
        cfg_bit_div   = 6'(bdiv);
        cfg_eof_words = 8'(eofw);
        repeat (2) @(negedge clk);
        cfg_rx_rst = 1'b0;
        m_pm = pm; m_cm = cm; m_w = (pm == 0 || pm == 1) ? 16 : 24;
        off = 0; prev_ws = 1'b0; have = 1'b0; cur = gen();
        accepted = 0; eof_seen = 0; sd_i = 1'b0;
        cfg_start = 1'b1;
        if (measure) begin
            @(posedge bck_o); t0 = $time;
            @(posedge bck_o);
            // R2: bit clock period
            chk(($time - t0) == time'(2 * (pdiv + 1) * (bdiv + 1) * PERIOD), "R2 period",
                32'($time - t0), 32'(2 * (pdiv + 1) * (bdiv + 1) * PERIOD));
        end
        repeat (frames) @(negedge ws_o);
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (10) @(negedge clk);
        expect_eof = (eofw != 0) ? accepted / eofw : 0;
        chk(eof_seen == expect_eof, {tag, " R9 eof count"}, 32'(eof_seen), 32'(expect_eof));
        if (rst_before_drain) begin
            cfg_rx_rst = 1'b1;
            repeat (2) @(negedge clk);
            cfg_rx_rst = 1'b0;
            chk(bck_o == 1'b0 && ws_o == 1'b0, "R12 clock lines idle",
                {30'd0, bck_o, ws_o}, 32'd0);
        end
        if (do_drain) drain(tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_start = 1'b0; cfg_rx_rst = 1'b0; cfg_fifo_rst = 1'b0;
        cfg_pack = '0; cfg_chan = '0; cfg_pre_div = '0; cfg_bit_div = '0;
        cfg_eof_words = '0; sd_i = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bck_o == 1'b0, "R1 bck reset", 32'(bck_o), 32'd0);
        chk(ws_o == 1'b0, "R1 ws reset", 32'(ws_o), 32'd0);
        chk(rd_valid == 1'b0, "R1 rd_valid reset", 32'(rd_valid), 32'd0);
        chk(ovf_o == 1'b0 && eof_o == 1'b0, "R1 flags reset", {30'd0, ovf_o, eof_o}, 32'd0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bck_o !== 1'b0) chk(1'b0, "R1 bck idle while stopped", 32'(bck_o), 32'd0);
        end
        chk(bck_o == 1'b0, "R1 bck idle after wait", 32'(bck_o), 32'd0);

        // R3 R6: 16-bit stereo, both channels, eof every 3 words (R9)
        run_test(0, 0, 0, 0, 3, 6, 1'b0, 1'b0, 1'b1, "R3 R6 s16 both");
        // R2 R12: left-only pairs, odd frame count, reset before drain keeps FIFO
        run_test(0, 2, 1, 1, 0, 5, 1'b1, 1'b1, 1'b1, "R12 s16 left");
        // R12: pairing restarts clean
        run_test(0, 0, 0, 0, 0, 2, 1'b0, 1'b0, 1'b1, "R12 s16 fresh pair");
        // R4 R7: 16-bit mono, right channel
        run_test(1, 1, 0, 1, 2, 4, 1'b1, 1'b0, 1'b1, "R4 R7 m16 right");
        // R5 R6: 24-bit stereo, right only
        run_test(2, 1, 0, 0, 0, 3, 1'b0, 1'b0, 1'b1, "R5 R6 s24 right");
        // R7: 24-bit mono with dual code keeps left
        run_test(3, 0, 0, 0, 0, 3, 1'b0, 1'b0, 1'b1, "R5 R7 m24 dual-code");
        run_test(3, 2, 1, 0, 0, 2, 1'b0, 1'b0, 1'b1, "R7 m24 left");
        // R6: keep none
        run_test(2, 3, 0, 0, 0, 2, 1'b0, 1'b0, 1'b1, "R6 keep none");
        // R8: illegal pack code
        run_test(5, 0, 0, 0, 1, 2, 1'b0, 1'b0, 1'b0, "R8 illegal pack");
        chk(rd_valid == 1'b0, "R8 nothing written", 32'(rd_valid), 32'd0);

        // R10 R11: overfill, then drain in order
        ovf_exp = 1'b0;
        run_test(2, 0, 0, 0, 16, 66, 1'b0, 1'b0, 1'b0, "R11 overfill");
        chk(ovf_o == ovf_exp && ovf_exp == 1'b1, "R11 overflow set", 32'(ovf_o), 32'd1);
        drain("R10 order after overfill");
        chk(ovf_o == 1'b1, "R11 overflow sticky", 32'(ovf_o), 32'd1);
        @(negedge clk);
        cfg_fifo_rst = 1'b1;
        @(negedge clk);
        cfg_fifo_rst = 1'b0;
        @(negedge clk);
        chk(ovf_o == 1'b0, "R11 overflow cleared", 32'(ovf_o), 32'd0);
        chk(rd_valid == 1'b0, "R11 FIFO empty after reset", 32'(rd_valid), 32'd0);
        ovf_exp = 1'b0;
        run_test(2, 2, 0, 0, 0, 2, 1'b0, 1'b0, 1'b1, "R10 refill after reset");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule